// File: doc/BRIEF.md
# Single/Double Precision Float Converter

This block turns an IEEE-754 binary32 value into binary64 or a binary64 value into binary32. The direction input picks which. A 64-bit operand word carries the source value. A binary32 source sits in bits 31:0, and bits 63:32 are ignored. A binary32 result is returned in bits 31:0 with bits 63:32 cleared.

Widening is always exact. Binary32 subnormals come out as normalised binary64 numbers. Narrowing rounds to nearest with ties to even, and this is the only rounding mode. Overflow saturates to a signed infinity. Values below the binary32 normal range become subnormals or a signed zero.

NaN inputs are not replaced by a fixed canonical NaN. The sign and as much of the payload as fits are carried across, and the quiet bit is forced. A default-NaN enable overrides this: with it set, any NaN gives the destination's default NaN, which is 0x7FC00000 for binary32 and 0x7FF8000000000000 for binary64.

A one-cycle start strobe launches a conversion. The result appears two clock edges later, together with a one-cycle valid pulse. A new operand may be started every cycle.

Top module: `prec_conv`

## Requirements
- R1: With dirNarrow=0, a normal binary32 in opIn[31:0] widens exactly: the exponent is rebiased by +896 and the fraction is placed in result bits 51:29 with bits 28:0 zero. opIn[63:32] has no effect on the result.
- R2: With dirNarrow=0, a nonzero binary32 subnormal widens to a normalised binary64 of the same value and sign.
- R3: Signed zeros and infinities convert to the same class and sign in either direction.
- R4: With dirNarrow=1, the binary32 result is rounded to nearest. An exact halfway case rounds to the value with an even last fraction bit.
- R5: With dirNarrow=1, a finite value whose rounded magnitude exceeds the largest finite binary32 becomes an infinity of the same sign.
- R6: With dirNarrow=1, a value below the binary32 normal range is rounded into a binary32 subnormal or a signed zero. A subnormal that rounds up past the top of that range becomes the smallest normal, 0x00800000.
- R7: With dnEn=0 and dirNarrow=0, a NaN keeps its sign. The result exponent is all ones (0x7FF). Payload bits 21:0 move to result bits 50:29, result bit 51 is forced to 1, and bits 28:0 are zero.
- R8: With dnEn=0 and dirNarrow=1, a NaN keeps its sign. The 8-bit exponent is all ones, payload bits 50:29 go to result bits 21:0, and result bit 22 is forced to 1.
- R9: With dnEn=1, any NaN input yields the default NaN of the destination: 0x7FC00000 for binary32, 0x7FF8000000000000 for binary64.
- R10: resValid is 1 exactly two clock edges after the edge that samples start=1, otherwise 0. resOut changes only when resValid rises with it and holds otherwise.
- R11: While rstN is low, resValid is 0 and resOut is zero.
- R12: When dirNarrow=1, result bits 63:32 are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Samples the operand, direction and NaN mode in this cycle |
| dirNarrow | input | 1 | 1 converts binary64 to binary32, 0 converts binary32 to binary64 |
| dnEn | input | 1 | 1 replaces every NaN result with the default NaN |
| opIn | input | 64 | Source value; binary32 uses bits 31:0 |
| resOut | output | 64 | Converted value; binary32 result in bits 31:0 |
| resValid | output | 1 | One-cycle pulse marking a new result |

## Verification
The properties look only at the operand, direction and mode values present in the cycle start is high. They therefore assume nothing about those inputs between starts, and the stimulus is free to change them at will. They do assume that reset is not asserted while a conversion is in flight. The stimulus only pulses reset at the beginning, with start held low. All inputs are driven on the falling edge, so each start cycle presents one complete, settled vector. The back-to-back case relies on the same per-cycle sampling.

// File: rtl/prec_conv_pkg.sv
package prec_conv_pkg;
  localparam int SGL_EXP_W = 8;
  localparam int SGL_MAN_W = 23;
  localparam int DBL_EXP_W = 11;
  localparam int DBL_MAN_W = 52;
  localparam int WORD_W    = 64;
  localparam int SGL_BIAS  = (1 << (SGL_EXP_W - 1)) - 1;
  localparam int DBL_BIAS  = (1 << (DBL_EXP_W - 1)) - 1;
  // exponent offset between formats, and derived narrowing thresholds
  localparam int BIAS_GAP     = DBL_BIAS - SGL_BIAS;
  localparam int MIN_NORM_EXP = BIAS_GAP + 1;
  localparam int OVF_EXP      = BIAS_GAP + (1 << SGL_EXP_W) - 1;
  localparam int SUB_BASE     = DBL_BIAS + DBL_MAN_W - (SGL_BIAS - 1 + SGL_MAN_W);
  localparam int MAX_SUB_SH   = 63;
  localparam int FLUSH_EXP    = SUB_BASE - MAX_SUB_SH;
  localparam int MAN_GAP      = DBL_MAN_W - SGL_MAN_W;

  localparam logic [31:0] SGL_DNAN = 32'h7FC0_0000;
  localparam logic [63:0] DBL_DNAN = 64'h7FF8_0000_0000_0000;

  typedef struct packed {
    logic loadEn;
    logic outEn;
  } strobe_t;

  function automatic logic [4:0] lead_zeros23(input logic [SGL_MAN_W-1:0] v);
    logic [4:0] n;
    logic hit;
    n = 5'd0;
    hit = 1'b0;
    for (int i = SGL_MAN_W - 1; i >= 0; i--) begin
      if (!hit && v[i]) begin
        n = 5'(SGL_MAN_W - 1 - i);
        hit = 1'b1;
      end
    end
    return n;
  endfunction
endpackage

// File: rtl/prec_conv_ctrl.sv
module prec_conv_ctrl
  import prec_conv_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output strobe_t stb,
  output logic    resValid
);
  logic stageQ;
  logic validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageQ <= 1'b0;
      validQ <= 1'b0;
    end else begin
      stageQ <= start;
      validQ <= stageQ;
    end
  end

  always_comb begin
    stb.loadEn = start;
    stb.outEn  = stageQ;
  end

  assign resValid = validQ;
endmodule

// File: rtl/prec_conv_dp.sv
module prec_conv_dp
  import prec_conv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              dirNarrow,
  input  logic              dnEn,
  input  logic [WORD_W-1:0] opIn,
  output logic [WORD_W-1:0] resOut
);
  localparam int EXT_W = 1 + DBL_MAN_W + MAX_SUB_SH;
  localparam int SH_W  = SGL_MAN_W + MAX_SUB_SH;

  logic [WORD_W-1:0] opQ;
  logic              narQ;
  logic              dnQ;
  logic [WORD_W-1:0] resQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ  <= '0;
      narQ <= 1'b0;
      dnQ  <= 1'b0;
    end else if (stb.loadEn) begin
      opQ  <= opIn;
      narQ <= dirNarrow;
      dnQ  <= dnEn;
    end
  end

  // binary32 -> binary64
  logic                 wS;
  logic [SGL_EXP_W-1:0] wE;
  logic [SGL_MAN_W-1:0] wM;
  logic [4:0]           wLz;
  logic [SGL_MAN_W-1:0] wNorm;
  logic [WORD_W-1:0]    widenRes;

  always_comb begin
    wS    = opQ[31];
    wE    = opQ[30:23];
    wM    = opQ[22:0];
    wLz   = lead_zeros23(wM);
    wNorm = wM << (wLz + 5'd1);
    if (wE == '1) begin
      if (wM == '0)  widenRes = {wS, 11'h7FF, 52'h0};
      else if (dnQ)  widenRes = DBL_DNAN;
      else           widenRes = {wS, 11'h7FF, 1'b1, wM[21:0], 29'h0};
    end else if (wE == '0) begin
      if (wM == '0)  widenRes = {wS, 63'h0};
      else           widenRes = {wS, 11'(BIAS_GAP) - {6'd0, wLz}, wNorm, 29'h0};
    end else begin
      widenRes = {wS, {3'b000, wE} + 11'(BIAS_GAP), wM, 29'h0};
    end
  end

  // binary64 -> binary32, round to nearest even
  logic                 nS;
  logic [DBL_EXP_W-1:0] nE;
  logic [DBL_MAN_W-1:0] nF;
  logic                 nRnd;
  logic [30:0]          nNormRes;
  logic [5:0]           nSh;
  logic [EXT_W-1:0]     nExt;
  logic [SH_W-1:0]      nShift;
  logic                 sRnd;
  logic [30:0]          nSubRes;
  logic [31:0]          narrowRes;

  always_comb begin
    nS       = opQ[63];
    nE       = opQ[62:52];
    nF       = opQ[51:0];
    nRnd     = nF[MAN_GAP-1] & ((|nF[MAN_GAP-2:0]) | nF[MAN_GAP]);
    nNormRes = {8'(nE - 11'(BIAS_GAP)), nF[51:MAN_GAP]} + 31'(nRnd);
    nSh      = 6'(11'(SUB_BASE) - nE);
    nExt     = {1'b1, nF, {MAX_SUB_SH{1'b0}}};
    nShift   = SH_W'(nExt >> nSh);
    sRnd     = nShift[MAX_SUB_SH-1] &
               ((|nShift[MAX_SUB_SH-2:0]) | nShift[MAX_SUB_SH]);
    nSubRes  = {8'h0, nShift[SH_W-1:MAX_SUB_SH]} + 31'(sRnd);
    if (nE == '1) begin
      if (nF == '0)  narrowRes = {nS, 8'hFF, 23'h0};
      else if (dnQ)  narrowRes = SGL_DNAN;
      else           narrowRes = {nS, 8'hFF, 1'b1, nF[50:MAN_GAP]};
    end else if (nE >= 11'(OVF_EXP)) begin
      narrowRes = {nS, 31'h7F80_0000};
    end else if (nE >= 11'(MIN_NORM_EXP)) begin
      narrowRes = {nS, nNormRes};
    end else if (nE >= 11'(FLUSH_EXP)) begin
      narrowRes = {nS, nSubRes};
    end else begin
      narrowRes = {nS, 31'h0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          resQ <= '0;
    else if (stb.outEn) resQ <= narQ ? {32'h0, narrowRes} : widenRes;
  end

  assign resOut = resQ;
endmodule

// File: rtl/prec_conv.sv
module prec_conv
  import prec_conv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        dirNarrow,
  input  logic        dnEn,
  input  logic [63:0] opIn,
  output logic [63:0] resOut,
  output logic        resValid
);
  strobe_t stb;

  prec_conv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stb(stb), .resValid(resValid)
  );

  prec_conv_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .dirNarrow(dirNarrow),
    .dnEn(dnEn), .opIn(opIn), .resOut(resOut)
  );
endmodule

// File: rtl/prec_conv_chk.sv
module prec_conv_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        dirNarrow,
  input logic        dnEn,
  input logic [63:0] opIn,
  input logic [63:0] resOut,
  input logic        resValid
);
  logic nanD;
  logic nanS;
  assign nanD = (opIn[62:52] == 11'h7FF) && (opIn[51:0] != 52'h0);
  assign nanS = (opIn[30:23] == 8'hFF) && (opIn[22:0] != 23'h0);

  p_valid_lat_r10: assert property (@(posedge clk) disable iff (!rstN)
    start |=> ##1 resValid) else $error("valid latency");

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> $stable(resOut)) else $error("result moved without valid");

  p_upper_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    start && dirNarrow |=> ##1 (resOut[63:32] == 32'h0)) else $error("upper not clear");

  p_dn_narrow_r9: assert property (@(posedge clk) disable iff (!rstN)
    start && dirNarrow && dnEn && nanD |=> ##1 (resOut == 64'h7FC0_0000))
    else $error("default nan single");

  p_dn_widen_r9: assert property (@(posedge clk) disable iff (!rstN)
    start && !dirNarrow && dnEn && nanS |=> ##1 (resOut == 64'h7FF8_0000_0000_0000))
    else $error("default nan double");

  p_ovf_inf_r5: assert property (@(posedge clk) disable iff (!rstN)
    start && dirNarrow && (opIn[62:52] >= 11'd1151) && (opIn[62:52] != 11'h7FF)
    |=> ##1 (resOut[30:0] == 31'h7F80_0000)) else $error("overflow not inf");

  p_nan_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    start && dirNarrow && !dnEn && nanD |=> ##1 (resOut[30:22] == 9'h1FF))
    else $error("narrow nan not quiet");

  p_nan_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    start && !dirNarrow && !dnEn && nanS
    |=> ##1 ((resOut[62:51] == 12'hFFF) && (resOut[28:0] == 29'h0)))
    else $error("widen nan shape");

  p_zero_keep_r3: assert property (@(posedge clk) disable iff (!rstN)
    start && !dirNarrow && (opIn[30:0] == 31'h0) |=> ##1 (resOut[62:0] == 63'h0))
    else $error("zero class lost");
endmodule

bind prec_conv prec_conv_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .dirNarrow(dirNarrow), .dnEn(dnEn),
  .opIn(opIn), .resOut(resOut), .resValid(resValid)
);

// File: tb/prec_conv_test.sv
`timescale 1ns/1ps
module prec_conv_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        dirNarrow = 1'b0;
  logic        dnEn = 1'b0;
  logic [63:0] opIn = '0;
  logic [63:0] resOut;
  logic        resValid;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prec_conv uut (
    .clk(clk), .rstN(rstN), .start(start), .dirNarrow(dirNarrow), .dnEn(dnEn),
    .opIn(opIn), .resOut(resOut), .resValid(resValid)
  );

  // {narrow, defaultNaN, operand, expected, requirement}
  localparam int NV = 32;
  localparam logic [133:0] VECS [NV] = '{
    {1'b0, 1'b0, 64'h0000_0000_3F80_0000, 64'h3FF0_0000_0000_0000, 4'd1},  // R1
    {1'b0, 1'b0, 64'hDEAD_BEEF_C020_0000, 64'hC004_0000_0000_0000, 4'd1},  // R1 upper ignored
    {1'b0, 1'b0, 64'h0000_0000_4049_0FDB, 64'h4009_21FB_6000_0000, 4'd1},  // R1
    {1'b0, 1'b0, 64'h0000_0000_0000_0001, 64'h36A0_0000_0000_0000, 4'd2},  // R2
    {1'b0, 1'b0, 64'h0000_0000_0040_0000, 64'h3800_0000_0000_0000, 4'd2},  // R2
    {1'b0, 1'b0, 64'h0000_0000_8000_0003, 64'hB6B8_0000_0000_0000, 4'd2},  // R2
    {1'b0, 1'b0, 64'h0000_0000_7F80_0000, 64'h7FF0_0000_0000_0000, 4'd3},  // R3
    {1'b0, 1'b0, 64'h0000_0000_8000_0000, 64'h8000_0000_0000_0000, 4'd3},  // R3
    {1'b1, 1'b0, 64'hFFF0_0000_0000_0000, 64'h0000_0000_FF80_0000, 4'd3},  // R3
    {1'b1, 1'b0, 64'h8000_0000_0000_0000, 64'h0000_0000_8000_0000, 4'd3},  // R3
    {1'b1, 1'b0, 64'h3FF0_0000_0000_0000, 64'h0000_0000_3F80_0000, 4'd4},  // R4
    {1'b1, 1'b0, 64'h3FF0_0000_1000_0000, 64'h0000_0000_3F80_0000, 4'd4},  // R4 tie to even down
    {1'b1, 1'b0, 64'h3FF0_0000_1000_0001, 64'h0000_0000_3F80_0001, 4'd4},  // R4 above half
    {1'b1, 1'b0, 64'h3FF0_0000_3000_0000, 64'h0000_0000_3F80_0002, 4'd4},  // R4 tie to even up
    {1'b1, 1'b0, 64'hBFF0_0000_3000_0000, 64'h0000_0000_BF80_0002, 4'd4},  // R4
    {1'b1, 1'b0, 64'h7E00_0000_0000_0000, 64'h0000_0000_7F80_0000, 4'd5},  // R5
    {1'b1, 1'b0, 64'h47F0_0000_0000_0000, 64'h0000_0000_7F80_0000, 4'd5},  // R5 edge
    {1'b1, 1'b0, 64'h47EF_FFFF_F000_0000, 64'h0000_0000_7F80_0000, 4'd5},  // R5 rounds over
    {1'b1, 1'b0, 64'h47EF_FFFF_E000_0000, 64'h0000_0000_7F7F_FFFF, 4'd5},  // R5 max finite
    {1'b1, 1'b0, 64'hC7F0_0000_0000_0000, 64'h0000_0000_FF80_0000, 4'd5},  // R5
    {1'b1, 1'b0, 64'h3810_0000_0000_0000, 64'h0000_0000_0080_0000, 4'd6},  // R6
    {1'b1, 1'b0, 64'h3800_0000_0000_0000, 64'h0000_0000_0040_0000, 4'd6},  // R6
    {1'b1, 1'b0, 64'h36A0_0000_0000_0000, 64'h0000_0000_0000_0001, 4'd6},  // R6
    {1'b1, 1'b0, 64'h3690_0000_0000_0000, 64'h0000_0000_0000_0000, 4'd6},  // R6 tie to zero
    {1'b1, 1'b0, 64'h3698_0000_0000_0000, 64'h0000_0000_0000_0001, 4'd6},  // R6
    {1'b1, 1'b0, 64'h380F_FFFF_FFFF_FFFF, 64'h0000_0000_0080_0000, 4'd6},  // R6 carry to normal
    {1'b1, 1'b0, 64'h8000_0000_0000_0001, 64'h0000_0000_8000_0000, 4'd6},  // R6
    {1'b0, 1'b0, 64'h0000_0000_7F80_0001, 64'h7FF8_0000_2000_0000, 4'd7},  // R7
    {1'b0, 1'b0, 64'h0000_0000_FFC0_0005, 64'hFFF8_0000_A000_0000, 4'd7},  // R7
    {1'b1, 1'b0, 64'h7FF4_0000_2000_0000, 64'h0000_0000_7FE0_0001, 4'd8},  // R8
    {1'b1, 1'b1, 64'h7FF4_0000_2000_0000, 64'h0000_0000_7FC0_0000, 4'd9},  // R9
    {1'b1, 1'b1, 64'hFFF8_0000_0000_0000, 64'h0000_0000_7FC0_0000, 4'd9}   // R9
  };

  task automatic check(input bit ok, input int rq, input logic [63:0] got,
                       input logic [63:0] want);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d got=%h want=%h", rq, got, want);
    end
  endtask

  task automatic runVec(input logic nar, input logic dn, input logic [63:0] op,
                        input logic [63:0] want, input int rq);
    @(negedge clk);
    start = 1'b1; dirNarrow = nar; dnEn = dn; opIn = op;
    @(negedge clk);
    start = 1'b0; opIn = ~op; dirNarrow = ~nar; dnEn = ~dn;
    check(resValid == 1'b0, 10, {63'h0, resValid}, 64'h0);  // R10 not yet
    @(negedge clk);
    check(resValid == 1'b1 && resOut == want, rq, resOut, want);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R10 watchdog got=timeout want=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(resValid == 1'b0 && resOut == 64'h0, 11, resOut, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(resValid == 1'b0 && resOut == 64'h0, 11, resOut, 64'h0);

    for (int i = 0; i < NV; i++)
      runVec(VECS[i][133], VECS[i][132], VECS[i][131:68], VECS[i][67:4],
             int'(VECS[i][3:0]));

    // R12: narrowed result must clear upper half even after a widen result
    runVec(1'b0, 1'b0, 64'h0000_0000_BF80_0000, 64'hBFF0_0000_0000_0000, 1);
    runVec(1'b1, 1'b0, 64'h3FF8_0000_0000_0000, 64'h0000_0000_3FC0_0000, 12);

    // R10: back-to-back starts, then hold
    @(negedge clk);
    start = 1'b1; dirNarrow = 1'b0; dnEn = 1'b0; opIn = 64'h0000_0000_3F80_0000;
    @(negedge clk);
    opIn = 64'h0000_0000_4000_0000;
    check(resValid == 1'b0, 10, {63'h0, resValid}, 64'h0);
    @(negedge clk);
    start = 1'b0;
    check(resValid && resOut == 64'h3FF0_0000_0000_0000, 10, resOut,
          64'h3FF0_0000_0000_0000);
    @(negedge clk);
    check(resValid && resOut == 64'h4000_0000_0000_0000, 10, resOut,
          64'h4000_0000_0000_0000);
    @(negedge clk);
    check(!resValid && resOut == 64'h4000_0000_0000_0000, 10, resOut,
          64'h4000_0000_0000_0000);
    repeat (3) @(negedge clk);
    check(!resValid && resOut == 64'h4000_0000_0000_0000, 10, resOut,
          64'h4000_0000_0000_0000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule